// File: doc/BRIEF.md
# Custom-Opcode Delta Instruction Execute Unit

This unit is the execute stage for a small set of delta-state instructions in a 64-bit RISC-V style core. It keeps two 64-bit registers of its own, a reference value and an XOR accumulator. The visible state is always the reference XOR the accumulator. Four R-type instructions in the custom-0 opcode space act on these registers:

- LOAD sets a new reference.
- ACCUM folds a delta into the accumulator.
- READ returns the reconstructed state.
- SWAP returns the reconstructed state and empties the accumulator in the same step.

The pipeline hands the unit an instruction word, the value already read for the first source register, and a valid strobe. The unit answers in the same cycle with a writeback enable, the destination index and the result. When an instruction is in the custom-0 space but uses an encoding the unit does not define, it raises an illegal-instruction flag instead. Instructions from any other opcode space pass through without effect. An ordinary ALU stage handles those instructions alongside this unit.

Because XOR is commutative and self-inverse, a series of ACCUM instructions leaves the same state whatever order the deltas arrive in. The results therefore depend only on which deltas were applied since the last LOAD or SWAP.

Top module: `delta_exec_unit`

## Requirements
- R1: After reset the reference and accumulator are both zero, and with valid low all outputs (`wb_en_o`, `illegal_o`, `result_o`) are zero; a READ issued right after reset returns zero.
- R2: The unit responds only when insn bits [6:0] equal 7'h0B. Any other opcode with valid high changes no state, keeps `wb_en_o` and `illegal_o` low and drives `result_o` to zero.
- R3: LOAD (funct3 = insn[14:12] = 3'b000, funct7 = insn[31:25] = 0) copies `rs1_val_i` into the reference, clears the accumulator from the next cycle, and asserts no writeback.
- R4: ACCUM (funct3 3'b001) XORs `rs1_val_i` into the accumulator from the next cycle, leaves the reference unchanged and asserts no writeback.
- R5: READ (funct3 3'b010) drives reference XOR accumulator on `result_o` in the same cycle, drives `wb_en_o` high when rd (insn[11:7]) is nonzero, and changes no state. `rd_idx_o` always shows insn[11:7].
- R6: SWAP (funct3 3'b011) drives the current reference XOR accumulator on `result_o` in the same cycle, and from the next cycle the accumulator is zero while the reference is kept.
- R7: READ and SWAP with rd = x0 keep `wb_en_o` low. A SWAP to x0 still clears the accumulator.
- R8: With opcode 7'h0B, a funct3 of 3'b100 to 3'b111 or a nonzero funct7 raises `illegal_o` in the same cycle. Such an instruction changes no state, asserts no writeback and drives `result_o` to zero; `illegal_o` and `wb_en_o` are never high together.
- R9: With `valid_i` low, no instruction word has any effect on state or outputs.
- R10: Each instruction completes in one cycle, so back-to-back instructions see each other's effects. After a LOAD, the state returned by READ equals the reference XOR all deltas accumulated since, whatever their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | Value of the first source register |
| wb_en_o | output | 1 | Write `result_o` to register `rd_idx_o` |
| rd_idx_o | output | 5 | Destination register index (insn[11:7]) |
| result_o | output | 64 | Reconstructed state for READ and SWAP, zero otherwise |
| illegal_o | output | 1 | Undefined custom-0 encoding |

## Verification
The assertions assume that `rst_ni` is low long enough to be sampled at a rising edge before any instruction. They also assume that `valid_i`, `insn_i` and `rs1_val_i` are settled at each rising edge, since the same-cycle result checks compare combinational outputs with the held state at that edge. The bench changes inputs only on falling edges and asserts reset for several cycles, including a second reset in the middle of the run. Its directed and pseudo-random instruction streams mix legal, illegal and foreign opcodes, with valid both high and low, so every assertion antecedent is reached under those conditions.

// File: rtl/delta_exec_pkg.sv
package delta_exec_pkg;

   // Fixed RISC-V R-type field positions (the decoder depends on these)
   localparam int OPC_LSB   = 0;
   localparam int OPC_W     = 7;
   localparam int RD_LSB    = 7;
   localparam int RIDX_W    = 5;
   localparam int F3_LSB    = 12;
   localparam int F3_W      = 3;
   localparam int SRC_LSB   = 15;
   localparam int SRC_W     = 10;
   localparam int F7_LSB    = 25;
   localparam int F7_W      = 7;

   localparam logic [OPC_W-1:0] OPC_CUSTOM0 = 7'h0B;

   typedef enum logic [1:0] {
      DOP_LOAD  = 2'b00,
      DOP_ACCUM = 2'b01,
      DOP_READ  = 2'b10,
      DOP_SWAP  = 2'b11
   } dop_e;

   typedef struct packed {
      logic              hit;      // valid and opcode matches
      logic              legal;    // defined delta operation
      logic              illegal;  // matching opcode, undefined encoding
      dop_e              op;
      logic [RIDX_W-1:0] rd;
   } dec_t;

endpackage

// File: rtl/delta_decode.sv
module delta_decode
   import delta_exec_pkg::*;
#(
   parameter int               ILEN      = 32,
   parameter logic [OPC_W-1:0] MATCH_OPC = OPC_CUSTOM0
) (
   input  logic            valid_i,
   input  logic [ILEN-1:0] insn_i,
   output dec_t            dec_o
);

   logic [OPC_W-1:0] opc;
   logic [F3_W-1:0]  f3;
   logic [F7_W-1:0]  f7;
   logic             unused_src_fields;

   assign opc = insn_i[OPC_LSB +: OPC_W];
   assign f3  = insn_i[F3_LSB  +: F3_W];
   assign f7  = insn_i[F7_LSB  +: F7_W];

   // Source register indices are resolved before this stage
   assign unused_src_fields = ^insn_i[SRC_LSB +: SRC_W];

   always_comb begin
      dec_o.hit     = valid_i && (opc == MATCH_OPC);
      dec_o.legal   = dec_o.hit && (f7 == '0) && !f3[2];
      dec_o.illegal = dec_o.hit && !dec_o.legal;
      dec_o.op      = dop_e'(f3[1:0]);
      dec_o.rd      = insn_i[RD_LSB +: RIDX_W];
   end

endmodule

// File: rtl/delta_state.sv
module delta_state
   import delta_exec_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  dec_t            dec_i,
   input  logic [XLEN-1:0] rs1_val_i,
   output logic [XLEN-1:0] ref_q,
   output logic [XLEN-1:0] acc_q,
   output logic [XLEN-1:0] cur_o
);

   logic unused_dec_bits;
   assign unused_dec_bits = dec_i.hit ^ dec_i.illegal ^ (^dec_i.rd);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= '0;
         acc_q <= '0;
      end else if (dec_i.legal) begin
         unique case (dec_i.op)
            DOP_LOAD: begin
               ref_q <= rs1_val_i;
               acc_q <= '0;
            end
            DOP_ACCUM: acc_q <= acc_q ^ rs1_val_i;
            DOP_SWAP:  acc_q <= '0;
            default: ;
         endcase
      end
   end

   // Reconstructed state, seen by READ/SWAP before this cycle's update
   assign cur_o = ref_q ^ acc_q;

endmodule

// File: rtl/delta_result.sv
module delta_result
   import delta_exec_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  dec_t              dec_i,
   input  logic [XLEN-1:0]   cur_i,
   output logic              wb_en_o,
   output logic [RIDX_W-1:0] rd_idx_o,
   output logic [XLEN-1:0]   result_o,
   output logic              illegal_o
);

   logic              produce;
   logic              wb_n;
   logic [XLEN-1:0]   res_n;
   logic              unused_hit;

   assign unused_hit = dec_i.hit;

   always_comb begin
      produce = dec_i.legal && ((dec_i.op == DOP_READ) || (dec_i.op == DOP_SWAP));
      wb_n    = produce && (dec_i.rd != '0);
      res_n   = produce ? cur_i : '0;
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            wb_en_o   <= 1'b0;
            rd_idx_o  <= '0;
            result_o  <= '0;
            illegal_o <= 1'b0;
         end else begin
            wb_en_o   <= wb_n;
            rd_idx_o  <= dec_i.rd;
            result_o  <= res_n;
            illegal_o <= dec_i.illegal;
         end
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign wb_en_o    = wb_n;
      assign rd_idx_o   = dec_i.rd;
      assign result_o   = res_n;
      assign illegal_o  = dec_i.illegal;
   end

endmodule

// File: rtl/delta_exec_unit.sv
module delta_exec_unit
   import delta_exec_pkg::*;
#(
   parameter int               XLEN      = 64,
   parameter int               ILEN      = 32,
   parameter logic [OPC_W-1:0] MATCH_OPC = OPC_CUSTOM0,
   parameter bit               OUT_REG   = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [ILEN-1:0]   insn_i,
   input  logic [XLEN-1:0]   rs1_val_i,
   output logic              wb_en_o,
   output logic [RIDX_W-1:0] rd_idx_o,
   output logic [XLEN-1:0]   result_o,
   output logic              illegal_o
);

   if (ILEN != 32) begin : g_bad_ilen
      $error("delta_exec_unit: ILEN must be 32, got %0d", ILEN);
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("delta_exec_unit: XLEN must be positive, got %0d", XLEN);
   end

   dec_t            dec;
   logic [XLEN-1:0] ref_q;
   logic [XLEN-1:0] acc_q;
   logic [XLEN-1:0] cur;

   delta_decode #(
      .ILEN      (ILEN),
      .MATCH_OPC (MATCH_OPC)
   ) u_dec (
      .valid_i (valid_i),
      .insn_i  (insn_i),
      .dec_o   (dec)
   );

   delta_state #(
      .XLEN (XLEN)
   ) u_state (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dec_i     (dec),
      .rs1_val_i (rs1_val_i),
      .ref_q     (ref_q),
      .acc_q     (acc_q),
      .cur_o     (cur)
   );

   delta_result #(
      .XLEN    (XLEN),
      .OUT_REG (OUT_REG)
   ) u_res (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dec_i     (dec),
      .cur_i     (cur),
      .wb_en_o   (wb_en_o),
      .rd_idx_o  (rd_idx_o),
      .result_o  (result_o),
      .illegal_o (illegal_o)
   );

endmodule

// File: rtl/delta_exec_unit_chk.sv
module delta_exec_unit_chk
   import delta_exec_pkg::*;
#(
   parameter int               XLEN      = 64,
   parameter int               ILEN      = 32,
   parameter logic [OPC_W-1:0] MATCH_OPC = OPC_CUSTOM0,
   parameter bit               OUT_REG   = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              valid_i,
   input logic [ILEN-1:0]   insn_i,
   input logic [XLEN-1:0]   rs1_val_i,
   input logic              wb_en_o,
   input logic [RIDX_W-1:0] rd_idx_o,
   input logic [XLEN-1:0]   result_o,
   input logic              illegal_o,
   input logic [XLEN-1:0]   ref_q,
   input logic [XLEN-1:0]   acc_q
);

   logic in_space, well_formed, foreign;
   logic [F3_W-1:0] f3;

   assign f3          = insn_i[F3_LSB +: F3_W];
   assign in_space    = valid_i && (insn_i[OPC_LSB +: OPC_W] == MATCH_OPC);
   assign foreign     = valid_i && (insn_i[OPC_LSB +: OPC_W] != MATCH_OPC);
   assign well_formed = in_space && (insn_i[F7_LSB +: F7_W] == '0) && (f3[2] == 1'b0);

   // R2
   foreign_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      foreign |=> $stable(ref_q) && $stable(acc_q));

   // R3
   load_sets_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      well_formed && f3 == 3'b000 |=> ref_q == $past(rs1_val_i) && acc_q == '0);

   // R4
   accum_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      well_formed && f3 == 3'b001 |=> acc_q == $past(acc_q ^ rs1_val_i) && $stable(ref_q));

   // R6
   swap_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      well_formed && f3 == 3'b011 |=> acc_q == '0 && $stable(ref_q));

   // R7
   wb_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_en_o |-> rd_idx_o != '0);

   // R8
   illegal_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_space && !well_formed |=> $stable(ref_q) && $stable(acc_q));

   // R8
   illegal_excl_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wb_en_o && illegal_o));

   // R9
   idle_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(ref_q) && $stable(acc_q));

   if (!OUT_REG) begin : g_same_cycle
      // R2
      foreign_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         foreign |-> !wb_en_o && !illegal_o && result_o == '0);

      // R5
      read_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         well_formed && f3[1] |-> result_o == (ref_q ^ acc_q));

      // R8
      illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_space && !well_formed |-> illegal_o && !wb_en_o && result_o == '0);
   end

endmodule

bind delta_exec_unit delta_exec_unit_chk #(
   .XLEN      (XLEN),
   .ILEN      (ILEN),
   .MATCH_OPC (MATCH_OPC),
   .OUT_REG   (OUT_REG)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .valid_i   (valid_i),
   .insn_i    (insn_i),
   .rs1_val_i (rs1_val_i),
   .wb_en_o   (wb_en_o),
   .rd_idx_o  (rd_idx_o),
   .result_o  (result_o),
   .illegal_o (illegal_o),
   .ref_q     (ref_q),
   .acc_q     (acc_q)
);

// File: tb/sim_delta_exec_unit.sv
module sim_delta_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] rs1 = '0;
   logic        wb_en;
   logic [4:0]  rd_idx;
   logic [63:0] result;
   logic        illegal;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   // Behavioural reference state
   logic [63:0] m_ref = '0;
   logic [63:0] m_acc = '0;

   always #4 clk = ~clk;

   delta_exec_unit u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .valid_i   (valid),
      .insn_i    (insn),
      .rs1_val_i (rs1),
      .wb_en_o   (wb_en),
      .rd_idx_o  (rd_idx),
      .result_o  (result),
      .illegal_o (illegal)
   );

   function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] opc);
      return {f7, 5'd6, 5'd10, f3, rd, opc};
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // One instruction per clock: drive at the falling edge, compare just after,
   // then advance the model so it matches the state after the next rising edge.
   task automatic exec(input string tag, input logic v, input logic [31:0] iw,
                       input logic [63:0] val);
      logic       hit, legal, prod, e_wb, e_ill;
      logic [63:0] e_res;
      logic [2:0] f3;
      @(negedge clk);
      valid = v; insn = iw; rs1 = val;
      #1;
      f3    = iw[14:12];
      hit   = v && (iw[6:0] == 7'h0B);
      legal = hit && (iw[31:25] == 7'd0) && (f3 < 3'd4);
      e_ill = hit && !legal;
      prod  = legal && (f3 == 3'd2 || f3 == 3'd3);
      e_res = prod ? (m_ref ^ m_acc) : 64'd0;
      e_wb  = prod && (iw[11:7] != 5'd0);
      checks++;
      if (wb_en !== e_wb || rd_idx !== iw[11:7] || result !== e_res || illegal !== e_ill) begin
         errors++;
         $display("FAIL %s: got wb=%0b rd=%0d res=%h ill=%0b expected wb=%0b rd=%0d res=%h ill=%0b",
                  tag, wb_en, rd_idx, result, illegal, e_wb, iw[11:7], e_res, e_ill);
      end
      if (legal) begin
         case (f3)
            3'd0: begin m_ref = val; m_acc = 64'd0; end
            3'd1: m_acc = m_acc ^ val;
            3'd3: m_acc = 64'd0;
            default: ;
         endcase
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      valid = 1'b0;
      rst_n = 1'b0;
      m_ref = '0;
      m_acc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   localparam logic [6:0] C0 = 7'h0B;

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      summary();
   end

   initial begin
      do_reset();
      // R1: idle outputs after reset, then READ returns zero
      exec("R1 idle", 1'b0, 32'd0, 64'd0);
      exec("R1 read after reset", 1'b1, mk(7'd0, 3'd2, 5'd1, C0), 64'd0);

      // R3 / R4 / R5: load, accumulate, read
      exec("R3 load", 1'b1, mk(7'd0, 3'd0, 5'd0, C0), 64'h0123_4567_89AB_CDEF);
      exec("R5 read after load", 1'b1, mk(7'd0, 3'd2, 5'd5, C0), 64'd0);
      exec("R4 accum", 1'b1, mk(7'd0, 3'd1, 5'd7, C0), 64'h0000_0000_0000_F00F);
      exec("R5 read after accum", 1'b1, mk(7'd0, 3'd2, 5'd31, C0), 64'd0);
      exec("R4 accum again", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'hFFFF_0000_0000_0001);
      exec("R5 read twice", 1'b1, mk(7'd0, 3'd2, 5'd2, C0), 64'd0);
      exec("R5 read stable", 1'b1, mk(7'd0, 3'd2, 5'd3, C0), 64'd0);

      // R2: foreign opcodes carrying custom-looking fields
      exec("R2 op 0x33", 1'b1, mk(7'd0, 3'd0, 5'd4, 7'h33), 64'hDEAD_0000_0000_0000);
      exec("R2 op 0x2B", 1'b1, mk(7'd0, 3'd1, 5'd4, 7'h2B), 64'h1111);
      exec("R2 op 0x0A", 1'b1, mk(7'd0, 3'd3, 5'd4, 7'h0A), 64'd0);
      exec("R2 state kept", 1'b1, mk(7'd0, 3'd2, 5'd4, C0), 64'd0);

      // R9: valid low with a custom instruction on the bus
      exec("R9 idle load", 1'b0, mk(7'd0, 3'd0, 5'd1, C0), 64'hAAAA);
      exec("R9 idle swap", 1'b0, mk(7'd0, 3'd3, 5'd1, C0), 64'd0);
      exec("R9 state kept", 1'b1, mk(7'd0, 3'd2, 5'd1, C0), 64'd0);

      // R8: undefined funct3 values and nonzero funct7
      for (int k = 4; k < 8; k++)
         exec("R8 funct3", 1'b1, mk(7'd0, 3'(k), 5'd9, C0), 64'h5555);
      exec("R8 funct7 load", 1'b1, mk(7'h20, 3'd0, 5'd9, C0), 64'h7777);
      exec("R8 funct7 accum", 1'b1, mk(7'h01, 3'd1, 5'd9, C0), 64'h7777);
      exec("R8 funct7 read", 1'b1, mk(7'h40, 3'd2, 5'd9, C0), 64'd0);
      exec("R8 state kept", 1'b1, mk(7'd0, 3'd2, 5'd9, C0), 64'd0);

      // R7: rd = x0 suppresses writeback, SWAP still clears
      exec("R7 read x0", 1'b1, mk(7'd0, 3'd2, 5'd0, C0), 64'd0);
      exec("R7 swap x0", 1'b1, mk(7'd0, 3'd3, 5'd0, C0), 64'd0);
      exec("R7 cleared", 1'b1, mk(7'd0, 3'd2, 5'd8, C0), 64'd0);

      // R6: swap returns prior state, then reference only
      exec("R6 accum", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h8000_0000_0000_00FF);
      exec("R6 swap", 1'b1, mk(7'd0, 3'd3, 5'd12, C0), 64'd0);
      exec("R6 after swap", 1'b1, mk(7'd0, 3'd2, 5'd12, C0), 64'd0);
      exec("R6 swap empty", 1'b1, mk(7'd0, 3'd3, 5'd13, C0), 64'd0);

      // R10: same deltas in two orders give the same state
      exec("R10 load A", 1'b1, mk(7'd0, 3'd0, 5'd0, C0), 64'hCAFE_F00D_0000_1234);
      exec("R10 d1", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h0F0F);
      exec("R10 d2", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h3000_0000_0000_0000);
      exec("R10 d3", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h00FF_0000);
      exec("R10 read order 1", 1'b1, mk(7'd0, 3'd2, 5'd20, C0), 64'd0);
      exec("R10 load B", 1'b1, mk(7'd0, 3'd0, 5'd0, C0), 64'hCAFE_F00D_0000_1234);
      exec("R10 d3", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h00FF_0000);
      exec("R10 d1", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h0F0F);
      exec("R10 d2", 1'b1, mk(7'd0, 3'd1, 5'd0, C0), 64'h3000_0000_0000_0000);
      exec("R10 read order 2", 1'b1, mk(7'd0, 3'd2, 5'd21, C0), 64'd0);

      // R1: reset in the middle clears loaded state
      do_reset();
      exec("R1 read after second reset", 1'b1, mk(7'd0, 3'd2, 5'd6, C0), 64'd0);

      // R5/R6/R8 mixed pseudo-random stream
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r;
         logic [6:0]  opc;
         logic [6:0]  f7;
         r   = $urandom;
         opc = (r[3:0] == 4'd0) ? 7'h13 : C0;
         f7  = (r[7:4] == 4'd0) ? 7'h02 : 7'd0;
         exec("R5/R6/R8 random", r[8] | r[9],
              mk(f7, r[12:10], r[17:13], opc), {$urandom, $urandom});
      end

      @(negedge clk);
      valid = 1'b0;
      summary();
   end

endmodule